// File: doc/BRIEF.md
# Dual Channel Angle Read Latch

This block sits between two angle trackers that run all the time and one shared 14-bit output bus that can be released. Each channel has a holding register. While its channel is not being read, the register copies its source on every clock. When a channel is selected and the bus is enabled, that channel's register is held, so a read never sees a word change halfway through. The tracker behind the register keeps running while the register is held.

The channel select and the active-low output enable come from outside the clock domain, so each passes through a two-stage synchronizer. The bus is modelled as a data word plus a separate drive-enable output, so the logic inside stays free of three-state nets. A settle counter raises a data-valid flag a fixed number of cycles after the bus is enabled or the channel changes. Any change on either control clears the flag at once.

Top module: `dual_angle_read_latch`

## Requirements
- R1: With the bus enabled, select level 1 puts channel A's held word on `bus_o`, and select level 0 puts channel B's held word there.
- R2: While the synchronized enable is inactive (`oe_ni` high), `bus_drive_o` is 0 and `bus_o` reads all zeros.
- R3: While a channel is selected and the bus is enabled, that channel's held word does not change, whatever its source does.
- R4: The channel that is not selected follows its source every cycle. After the select changes, the bus shows that channel's latest source value.
- R5: After `oe_ni` falls, `data_valid_o` rises exactly SETTLE_CYCLES+3 rising edges later: two synchronizer stages, one edge to clear the counter, and SETTLE_CYCLES counting edges.
- R6: A change of select while the bus is enabled drops `data_valid_o` two edges after the input changes. The flag rises again exactly SETTLE_CYCLES+3 edges after that input change.
- R7: `bus_drive_o` follows `oe_ni` inverted, with exactly two edges of delay in both directions. The bus is therefore released two edges after `oe_ni` rises.
- R8: The bus word is natural binary with the most significant weight on bit 13. It carries the source bit pattern unchanged.
- R9: During and right after reset, `bus_drive_o`, `data_valid_o` and `bus_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ang_a_i | input | 14 | Channel A angle source |
| ang_b_i | input | 14 | Channel B angle source |
| sel_a_i | input | 1 | Channel select, 1 = A, 0 = B (asynchronous) |
| oe_ni | input | 1 | Output enable, active low (asynchronous) |
| bus_o | output | 14 | Shared data word, zero while not driven |
| bus_drive_o | output | 1 | Bus drive enable, 1 = driven |
| data_valid_o | output | 1 | Bus data has settled |

## Verification
Assertions check on every cycle that a held register stays still while it is frozen, and that a free register copies its source of the previous cycle. They also check that the flag is never high while the bus is released or on a cycle where the select changed, that the released bus reads zero, and that the drive follows the enable two cycles late. The bench scenarios cover what needs a whole sequence: the exact edge count to validity after an enable or a select change, which channel's value appears, a source change hidden during a read, and the update of the other channel seen after switching.

// File: rtl/arl_pkg.sv
package arl_pkg;
  localparam int unsigned ANGLE_W = 14;
  typedef enum logic {CH_B = 1'b0, CH_A = 1'b1} chan_e;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         freeze_i,
  output logic [W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_o <= '0;
    else if (!freeze_i) hold_o <= src_i;
  end

  a_r3_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(hold_o));
  a_r4_free_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i |=> hold_o == $past(src_i));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic oe_n_i,
  output logic valid_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q, oe_n_q, ctrl_chg;

  assign ctrl_chg = (sel_i ^ sel_q) | (oe_n_i ^ oe_n_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      oe_n_q <= 1'b1;
    end else begin
      sel_q  <= sel_i;
      oe_n_q <= oe_n_i;
      if (oe_n_i || ctrl_chg) cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = !oe_n_i && !ctrl_chg && (cnt_q == CNT_MAX);

  a_r5_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  a_r5_rise_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(cnt_q) == CNT_MAX || $past(cnt_q) == CNT_MAX - 1'b1);
endmodule

// File: rtl/dual_angle_read_latch.sv
module dual_angle_read_latch
  import arl_pkg::*;
#(
  parameter int unsigned W             = ANGLE_W,
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ang_a_i,
  input  logic [W-1:0] ang_b_i,
  input  logic         sel_a_i,
  input  logic         oe_ni,
  output logic [W-1:0] bus_o,
  output logic         bus_drive_o,
  output logic         data_valid_o
);
  localparam int unsigned NCH = 2;

  logic [1:0]         ctrl_s;
  chan_e              sel_s;
  logic               oe_n_s, rd_en;
  logic [NCH-1:0][W-1:0] src, hold;

  // bit 1 = select, bit 0 = enable_n; reset to B, bus released
  ctrl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_a_i, oe_ni}),
    .q_o   (ctrl_s)
  );

  assign sel_s  = chan_e'(ctrl_s[1]);
  assign oe_n_s = ctrl_s[0];
  assign rd_en  = !oe_n_s;

  assign src[CH_A] = ang_a_i;
  assign src[CH_B] = ang_b_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    hold_latch #(.W(W)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src[ch]),
      .freeze_i(rd_en && (sel_s == chan_e'(ch))),
      .hold_o  (hold[ch])
    );
  end

  settle_timer #(.SETTLE(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_s),
    .oe_n_i (oe_n_s),
    .valid_o(data_valid_o)
  );

  assign bus_drive_o = rd_en;
  assign bus_o       = rd_en ? hold[sel_s] : '0;

  a_r2_released_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_drive_o |-> bus_o == '0);
  a_r5_valid_needs_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> bus_drive_o);
  a_r6_sel_change_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_s != $past(sel_s)) |-> !data_valid_o);
  a_r7_release_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(oe_ni) && $past(oe_ni, 2)) |-> !bus_drive_o);
endmodule

// File: tb/dual_angle_read_latch_bench.sv
module dual_angle_read_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 14;
  localparam int S = 4;

  logic         clk = 0, rst_n = 0;
  logic [W-1:0] ang_a = '0, ang_b = '0;
  logic         sel_a = 0, oe_n = 1;
  logic [W-1:0] bus;
  logic         drive, valid;
  int           n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_angle_read_latch #(.W(W), .SETTLE_CYCLES(S)) u_dual_angle_read_latch (
    .clk_i(clk), .rst_ni(rst_n), .ang_a_i(ang_a), .ang_b_i(ang_b),
    .sel_a_i(sel_a), .oe_ni(oe_n), .bus_o(bus), .bus_drive_o(drive),
    .data_valid_o(valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_valid(input int start, output int n);
    n = start;
    do begin @(posedge clk); n++; @(negedge clk); end
    while (!valid && n < 64);
  endtask

  function automatic logic [W-1:0] pat(input int k);
    case (k)
      0: pat = 14'h0000;
      1: pat = 14'h3FFF;
      2: pat = 14'h2000;
      3: pat = 14'h0001;
      default: pat = W'((k * 4729 + 311) % (1 << W));
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] a, b, na, nb, expv;
    @(negedge clk);
    chk("R9 drive in reset", drive, 0);
    chk("R9 valid in reset", valid, 0);
    cyc(2); rst_n = 1; cyc(1);
    chk("R9 drive after reset", drive, 0);
    chk("R9 valid after reset", valid, 0);
    chk("R9 bus after reset", bus, 0);

    for (int k = 0; k < 8; k++) begin
      for (int chs = 0; chs < 2; chs++) begin
        a = pat(k); b = pat(k) ^ 14'h1555;
        na = ~a; nb = ~b;
        ang_a = a; ang_b = b; sel_a = chs[0]; oe_n = 1;
        cyc(4);
        oe_n = 0;
        @(posedge clk); @(negedge clk);
        chk("R7 drive not yet after 1 edge", drive, 0);
        wait_valid(1, n);
        chk("R5 edges to valid", n, S + 3);
        expv = chs ? a : b;
        chk("R1 selected channel on bus", bus, expv);
        chk("R8 msb position", bus[W-1], expv[W-1]);
        chk("R7 drive on", drive, 1);
        ang_a = na; ang_b = nb;
        cyc(3);
        chk("R3 frozen during read", bus, expv);
        sel_a = ~chs[0];
        cyc(2);
        chk("R6 valid dropped on select change", valid, 0);
        wait_valid(2, n);
        chk("R6 edges to valid after select", n, S + 3);
        chk("R4 other channel followed source", bus, chs ? nb : na);
        oe_n = 1;
        @(posedge clk); @(negedge clk);
        chk("R7 still driven after 1 edge", drive, 1);
        @(posedge clk); @(negedge clk);
        chk("R7 released after 2 edges", drive, 0);
        chk("R2 bus zero when released", bus, 0);
        chk("R2 valid low when released", valid, 0);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule